// File: doc/BRIEF.md
# Wavefront Issue Readiness Gate

This block sits beside one wavefront slot of a compute unit's scheduler. Each cycle it looks at the instruction at the head of the wavefront's buffer and decides whether that instruction may be issued to the pipeline class the scheduler is asking about. The classes are vector ALU, global memory, shared (local) memory, private memory and flat memory. The answer depends on the wavefront's run state, a pending barrier, free issue slots and VRF-to-memory buses, request FIFO space, operand readiness, and memory-ordering hazards within each address space.

The gate keeps its own record of memory traffic that is in flight: read and write counts for the global space, read and write counts for the local space, and a total count. When the scheduler takes an instruction that is ready, the gate raises the matching counters. It also starts countdown timers for the SIMD issue slot, the global and local memory issue slots, and the global and local VRF-to-memory buses. Completion pulses from the memory pipelines lower the counters. A completion pulse that arrives for a counter already at zero sets a sticky error flag.

Top module: `wf_issue_gate`

## Requirements
- R1: `rdy` is low whenever `wf_state` is not running, or when `ibuf_empty` is high. The encodings are 0 = stopped, 1 = running and 2 = returning.
- R2: Issuing a barrier (op 3) raises `bar_wait`. While `bar_wait` is high and `all_at_bar` is low, `rdy` stays low. In a cycle where `all_at_bar` is high, readiness is judged normally, and `bar_wait` clears at that clock edge.
- R3: Return (op 2) and barrier (op 3) are ready on pipe 0 only when the SIMD issue slot is free and the total in-flight count is zero.
- R4: Global reads (op 4) and private reads (op 10) wait for zero global writes. Global writes (5) and private writes (11) wait for zero global reads. Atomics (6, 12) wait for both. Global ops use pipe 1 and private ops use pipe 3. Both need the global bus, the global issue slot, `gfifo_space` and `opnd_ready`.
- R5: Local reads (7), writes (8) and atomics (9) on pipe 2 obey the same read/write hazard rule, using the local counters, the local bus, the local slot and `lfifo_space`.
- R6: Flat reads (13) and flat writes (14) on pipe 4 need both buses, both memory issue slots, both FIFOs with space, and `opnd_ready`.
- R7: When a memory op issues, its bus is blocked for the following RD_BUS_CYC cycles for a read, or WR_BUS_CYC cycles for a write or atomic. Its memory slot is blocked for the following ISSUE_PERIOD cycles.
- R8: An issued atomic raises both the read count and the write count of its space. Every memory op raises the total count. Flat ops count in the global counters, and `flat_to_local` picks only the bus and slot they use.
- R9: On pipe 0, ALU ops (1) need `opnd_ready` and a free SIMD slot, while NOP (0) needs only the free slot. Issuing any op on pipe 0 blocks the SIMD slot for the following ISSUE_PERIOD cycles.
- R10: Bits of `cpl_pulse` lower one counter each: [0] global read, [1] global write, [2] local read, [3] local write, [4] total. A pulse on a counter at zero leaves it at zero and sets `cnt_err`, which stays set until reset.
- R11: Op 15, or any op presented with a pipe class other than its own, is never ready.
- R12: An instruction issues only when `issue_take` and `rdy` are both high. A take while not ready changes no counter and no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wf_state | input | 2 | Wavefront run state |
| ibuf_empty | input | 1 | Instruction buffer is empty |
| head_op | input | 4 | Operation class of the head instruction |
| req_pipe | input | 3 | Pipeline class being queried |
| flat_to_local | input | 1 | Flat op resolved to local space |
| all_at_bar | input | 1 | All wavefronts of the group reached the barrier |
| gfifo_space | input | 1 | Global request FIFO can accept |
| lfifo_space | input | 1 | Local request FIFO can accept |
| opnd_ready | input | 1 | Operands of the head instruction are ready |
| issue_take | input | 1 | Scheduler issues the head instruction if ready |
| cpl_pulse | input | 5 | Completion pulses per counter |
| rdy | output | 1 | Head instruction may issue to `req_pipe` |
| bar_wait | output | 1 | Wavefront is stalled at a barrier |
| cnt_err | output | 1 | Sticky counter underflow flag |

## Verification
The bench builds the gate with ISSUE_PERIOD = 3, RD_BUS_CYC = 4 and WR_BUS_CYC = 8. With these values, the slot period, the read bus window and the write bus window all differ. Each timer's last blocked cycle can therefore be told apart from its neighbours, and a write-bus window is long enough to let a hazard be seen once its bus is already free. A 4-bit counter width lets two writes of the same space be in flight together.

// File: rtl/wig_pkg.sv
package wig_pkg;
  typedef enum logic [1:0] {WS_STOP = 2'd0, WS_RUN = 2'd1, WS_RET = 2'd2} wstate_e;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,  OP_ALU = 4'd1,  OP_RET = 4'd2,   OP_BAR = 4'd3,
    OP_GRD = 4'd4,  OP_GWR = 4'd5,  OP_GATM = 4'd6,
    OP_LRD = 4'd7,  OP_LWR = 4'd8,  OP_LATM = 4'd9,
    OP_PRD = 4'd10, OP_PWR = 4'd11, OP_PATM = 4'd12,
    OP_FRD = 4'd13, OP_FWR = 4'd14, OP_BAD = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    PIPE_ALU = 3'd0, PIPE_GLB = 3'd1, PIPE_SHR = 3'd2, PIPE_PRV = 3'd3, PIPE_FLT = 3'd4
  } pipe_e;

  localparam int NCNT   = 5;
  localparam int CI_GRD = 0;
  localparam int CI_GWR = 1;
  localparam int CI_LRD = 2;
  localparam int CI_LWR = 3;
  localparam int CI_TOT = 4;

  localparam int NTMR     = 5;
  localparam int TI_SIMD  = 0;
  localparam int TI_GSLOT = 1;
  localparam int TI_LSLOT = 2;
  localparam int TI_GBUS  = 3;
  localparam int TI_LBUS  = 4;
endpackage

// File: rtl/wig_countdown.sv
module wig_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         free
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign free = (cnt_q == '0);
endmodule

// File: rtl/wig_flight_cnt.sv
module wig_flight_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         underflow
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign underflow = dec & ~inc & (count == '0);
  assign cnt_en    = (inc ^ dec) & ~underflow;

  always_comb begin
    if (inc) cnt_d = count + 1'b1;
    else     cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end
endmodule

// File: rtl/wig_ready.sv
module wig_ready
  import wig_pkg::*;
(
  input  wstate_e         st,
  input  logic            buf_empty,
  input  logic            stall,
  input  logic            bar_release,
  input  op_e             op,
  input  pipe_e           pipe,
  input  logic [NTMR-1:0] tfree,
  input  logic [NCNT-1:0] czero,
  input  logic            gfifo,
  input  logic            lfifo,
  input  logic            opnd,
  output logic            rdy
);
  logic  live, gpath, lpath;
  pipe_e gpipe;

  assign live  = (st == WS_RUN) & ~buf_empty & (~stall | bar_release);
  assign gpath = tfree[TI_GBUS] & tfree[TI_GSLOT] & gfifo & opnd;
  assign lpath = tfree[TI_LBUS] & tfree[TI_LSLOT] & lfifo & opnd;
  assign gpipe = (op inside {OP_PRD, OP_PWR, OP_PATM}) ? PIPE_PRV : PIPE_GLB;

  always_comb begin
    rdy = 1'b0;
    if (live) begin
      case (op)
        OP_NOP:          rdy = (pipe == PIPE_ALU) & tfree[TI_SIMD];
        OP_ALU:          rdy = (pipe == PIPE_ALU) & tfree[TI_SIMD] & opnd;
        OP_RET, OP_BAR:  rdy = (pipe == PIPE_ALU) & tfree[TI_SIMD] & czero[CI_TOT];
        OP_GRD, OP_PRD:  rdy = (pipe == gpipe) & czero[CI_GWR] & gpath;
        OP_GWR, OP_PWR:  rdy = (pipe == gpipe) & czero[CI_GRD] & gpath;
        OP_GATM, OP_PATM: rdy = (pipe == gpipe) & czero[CI_GRD] & czero[CI_GWR] & gpath;
        OP_LRD:          rdy = (pipe == PIPE_SHR) & czero[CI_LWR] & lpath;
        OP_LWR:          rdy = (pipe == PIPE_SHR) & czero[CI_LRD] & lpath;
        OP_LATM:         rdy = (pipe == PIPE_SHR) & czero[CI_LRD] & czero[CI_LWR] & lpath;
        OP_FRD, OP_FWR:  rdy = (pipe == PIPE_FLT) & gpath & lpath;
        default:         rdy = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wf_issue_gate.sv
module wf_issue_gate
  import wig_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int TMR_W        = 4,
  parameter int ISSUE_PERIOD = 3,
  parameter int RD_BUS_CYC   = 4,
  parameter int WR_BUS_CYC   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wf_state,
  input  logic       ibuf_empty,
  input  logic [3:0] head_op,
  input  logic [2:0] req_pipe,
  input  logic       flat_to_local,
  input  logic       all_at_bar,
  input  logic       gfifo_space,
  input  logic       lfifo_space,
  input  logic       opnd_ready,
  input  logic       issue_take,
  input  logic [4:0] cpl_pulse,
  output logic       rdy,
  output logic       bar_wait,
  output logic       cnt_err
);
  localparam logic [TMR_W-1:0] PERIOD_V = TMR_W'(ISSUE_PERIOD);
  localparam logic [TMR_W-1:0] RDBUS_V  = TMR_W'(RD_BUS_CYC);
  localparam logic [TMR_W-1:0] WRBUS_V  = TMR_W'(WR_BUS_CYC);

  op_e     op;
  pipe_e   pipe;
  wstate_e st;
  assign op   = op_e'(head_op);
  assign pipe = pipe_e'(req_pipe);
  assign st   = wstate_e'(wf_state);

  logic [NCNT-1:0][CNT_W-1:0] flight_cnt;
  logic [NCNT-1:0]            cnt_inc, cnt_unf, cnt_zero;
  logic [NTMR-1:0]            tmr_load, tmr_free;
  logic [NTMR-1:0][TMR_W-1:0] tmr_val;
  logic fire, stall_set, stall_q, stall_d, err_q, err_d;
  logic is_mem, rd_kind, wr_kind, cnt_local, path_local;

  // R7 R9: one countdown per issue slot and per bus
  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    wig_countdown #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load[t]), .load_val(tmr_val[t]), .free(tmr_free[t]));
  end

  // R8 R10: in-flight counters, decremented by completion pulses
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    wig_flight_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[c]), .dec(cpl_pulse[c]),
      .count(flight_cnt[c]), .underflow(cnt_unf[c]));
    assign cnt_zero[c] = (flight_cnt[c] == '0);
  end

  wig_ready u_rdy (
    .st(st), .buf_empty(ibuf_empty), .stall(stall_q), .bar_release(all_at_bar),
    .op(op), .pipe(pipe), .tfree(tmr_free), .czero(cnt_zero),
    .gfifo(gfifo_space), .lfifo(lfifo_space), .opnd(opnd_ready), .rdy(rdy));

  // R12: issue happens only on a take of a ready instruction
  assign fire = issue_take & rdy;

  assign is_mem     = op inside {[OP_GRD:OP_FWR]};
  assign rd_kind    = op inside {OP_GRD, OP_GATM, OP_LRD, OP_LATM, OP_PRD, OP_PATM, OP_FRD};
  assign wr_kind    = op inside {OP_GWR, OP_GATM, OP_LWR, OP_LATM, OP_PWR, OP_PATM, OP_FWR};
  assign cnt_local  = op inside {OP_LRD, OP_LWR, OP_LATM};
  assign path_local = cnt_local | ((op inside {OP_FRD, OP_FWR}) & flat_to_local);

  always_comb begin
    cnt_inc   = '0;
    tmr_load  = '0;
    tmr_val   = '0;
    stall_set = 1'b0;
    if (fire) begin
      if (!is_mem) begin
        tmr_load[TI_SIMD] = 1'b1;
        tmr_val[TI_SIMD]  = PERIOD_V;
        stall_set         = (op == OP_BAR);
      end else begin
        cnt_inc[CI_TOT] = 1'b1;
        if (cnt_local) begin
          cnt_inc[CI_LRD] = rd_kind;
          cnt_inc[CI_LWR] = wr_kind;
        end else begin
          cnt_inc[CI_GRD] = rd_kind;
          cnt_inc[CI_GWR] = wr_kind;
        end
        if (path_local) begin
          tmr_load[TI_LBUS]  = 1'b1;
          tmr_val[TI_LBUS]   = wr_kind ? WRBUS_V : RDBUS_V;
          tmr_load[TI_LSLOT] = 1'b1;
          tmr_val[TI_LSLOT]  = PERIOD_V;
        end else begin
          tmr_load[TI_GBUS]  = 1'b1;
          tmr_val[TI_GBUS]   = wr_kind ? WRBUS_V : RDBUS_V;
          tmr_load[TI_GSLOT] = 1'b1;
          tmr_val[TI_GSLOT]  = PERIOD_V;
        end
      end
    end
  end

  // R2 barrier stall and R10 sticky error
  always_comb begin
    stall_d = stall_q;
    if (stall_q && all_at_bar) stall_d = 1'b0;
    if (stall_set)             stall_d = 1'b1;
    err_d = err_q | (|cnt_unf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stall_q <= stall_d;
      err_q   <= err_d;
    end
  end

  assign bar_wait = stall_q;
  assign cnt_err  = err_q;
endmodule

// File: rtl/wig_checker.sv
module wig_checker #(
  parameter int CNT_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rdy,
  input logic [1:0]           wf_state,
  input logic                 ibuf_empty,
  input logic [3:0]           head_op,
  input logic [2:0]           req_pipe,
  input logic                 all_at_bar,
  input logic                 bar_wait,
  input logic                 cnt_err,
  input logic [4:0][CNT_W-1:0] flight
);
  a_r1_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_state != 2'd1 || ibuf_empty) |-> !rdy);

  a_r11_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (head_op == 4'd15) |-> !rdy);

  a_r2_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_wait && !all_at_bar) |-> !rdy);

  a_r3_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && req_pipe == 3'd0 && (head_op == 4'd2 || head_op == 4'd3)) |-> (flight[4] == '0));

  a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && (head_op == 4'd4 || head_op == 4'd10)) |-> (flight[1] == '0));

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && (head_op == 4'd5 || head_op == 4'd11)) |-> (flight[0] == '0));

  a_r5_local_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && head_op == 4'd7) |-> (flight[3] == '0));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err);
endmodule

bind wf_issue_gate wig_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .wf_state(wf_state), .ibuf_empty(ibuf_empty),
  .head_op(head_op), .req_pipe(req_pipe), .all_at_bar(all_at_bar), .bar_wait(bar_wait),
  .cnt_err(cnt_err), .flight(flight_cnt));

// File: tb/wf_issue_gate_test.sv
module wf_issue_gate_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] wf_state;
  logic       ibuf_empty, flat_to_local, all_at_bar;
  logic [3:0] head_op;
  logic [2:0] req_pipe;
  logic       gfifo_space, lfifo_space, opnd_ready, issue_take;
  logic [4:0] cpl_pulse;
  logic       rdy, bar_wait, cnt_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wf_issue_gate #(.CNT_W(4), .TMR_W(4), .ISSUE_PERIOD(3), .RD_BUS_CYC(4), .WR_BUS_CYC(8)) uut (
    .clk(clk), .rst_n(rst_n), .wf_state(wf_state), .ibuf_empty(ibuf_empty),
    .head_op(head_op), .req_pipe(req_pipe), .flat_to_local(flat_to_local),
    .all_at_bar(all_at_bar), .gfifo_space(gfifo_space), .lfifo_space(lfifo_space),
    .opnd_ready(opnd_ready), .issue_take(issue_take), .cpl_pulse(cpl_pulse),
    .rdy(rdy), .bar_wait(bar_wait), .cnt_err(cnt_err));

  // vector: {req tag, state, empty, op, pipe, gfifo, lfifo, opnd, expected rdy}
  localparam int NVEC = 16;
  localparam logic [17:0] VEC [NVEC] = '{
    {4'd1,  2'd0, 1'b0, 4'd1,  3'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R1 stopped
    {4'd1,  2'd2, 1'b0, 4'd1,  3'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R1 returning
    {4'd1,  2'd1, 1'b1, 4'd1,  3'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R1 empty buffer
    {4'd9,  2'd1, 1'b0, 4'd1,  3'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R9 alu ready
    {4'd9,  2'd1, 1'b0, 4'd1,  3'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R9 operands pending
    {4'd9,  2'd1, 1'b0, 4'd0,  3'd0, 1'b1, 1'b1, 1'b0, 1'b1},  // R9 nop ignores operands
    {4'd3,  2'd1, 1'b0, 4'd2,  3'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R3 return drained
    {4'd4,  2'd1, 1'b0, 4'd4,  3'd1, 1'b1, 1'b1, 1'b1, 1'b1},  // R4 global read
    {4'd4,  2'd1, 1'b0, 4'd4,  3'd1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 global fifo full
    {4'd11, 2'd1, 1'b0, 4'd4,  3'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R11 wrong pipe
    {4'd11, 2'd1, 1'b0, 4'd15, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R11 unknown op
    {4'd5,  2'd1, 1'b0, 4'd8,  3'd2, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 local write
    {4'd6,  2'd1, 1'b0, 4'd13, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0},  // R6 flat, local fifo full
    {4'd6,  2'd1, 1'b0, 4'd13, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 flat ready
    {4'd4,  2'd1, 1'b0, 4'd12, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1},  // R4 private atomic
    {4'd11, 2'd1, 1'b0, 4'd12, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0}   // R11 private on global pipe
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_op(input logic [3:0] o, input logic [2:0] p);
    head_op = o;
    req_pipe = p;
    #1;
  endtask

  task automatic pulse(input logic [4:0] bits);
    cpl_pulse = bits;
    @(negedge clk);
    cpl_pulse = '0;
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wf_state = 2'd0; ibuf_empty = 1'b1; head_op = 4'd0; req_pipe = 3'd0;
    flat_to_local = 1'b0; all_at_bar = 1'b0; gfifo_space = 1'b1; lfifo_space = 1'b1;
    opnd_ready = 1'b1; issue_take = 1'b0; cpl_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("reset R1 rdy", rdy, 1'b0);
    chk("reset R2 bar_wait", bar_wait, 1'b0);
    chk("reset R10 cnt_err", cnt_err, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wf_state, ibuf_empty, head_op, req_pipe, gfifo_space, lfifo_space, opnd_ready} = VEC[i][16:1];
      #1;
      chk($sformatf("R%0d vector %0d", VEC[i][17:14], i), rdy, VEC[i][0]);
    end

    wf_state = 2'd1; ibuf_empty = 1'b0; gfifo_space = 1'b1; lfifo_space = 1'b1; opnd_ready = 1'b1;

    // R7 read bus window, R4 write waits on read, R3 return waits for drain
    @(negedge clk); set_op(4'd4, 3'd1); issue_take = 1'b1; #1;
    chk("R4 global read issue", rdy, 1'b1);
    @(negedge clk); issue_take = 1'b0; #1;
    chk("R7 read bus busy first cycle", rdy, 1'b0);
    repeat (3) @(negedge clk); #1;
    chk("R7 read bus busy last cycle", rdy, 1'b0);
    @(negedge clk); #1;
    chk("R7 read bus free, reads pass reads", rdy, 1'b1);
    set_op(4'd5, 3'd1);
    chk("R4 write blocked by read", rdy, 1'b0);
    set_op(4'd2, 3'd0);
    chk("R3 return blocked by in-flight", rdy, 1'b0);
    pulse(5'b10001);
    chk("R3 return after completion", rdy, 1'b1);
    set_op(4'd5, 3'd1);
    chk("R10 R4 write after read completes", rdy, 1'b1);

    // R7 write bus window, R5 local hazard, R10 underflow
    @(negedge clk); set_op(4'd8, 3'd2); issue_take = 1'b1; #1;
    chk("R5 local write issue", rdy, 1'b1);
    @(negedge clk); issue_take = 1'b0;
    repeat (7) @(negedge clk); #1;
    chk("R7 write bus busy last cycle", rdy, 1'b0);
    @(negedge clk); #1;
    chk("R7 write bus free, writes pass writes", rdy, 1'b1);
    issue_take = 1'b1;
    @(negedge clk); issue_take = 1'b0;
    repeat (8) @(negedge clk); #1;
    chk("R5 second write bus free", rdy, 1'b1);
    set_op(4'd7, 3'd2);
    chk("R5 local read blocked by two writes", rdy, 1'b0);
    pulse(5'b11000);
    chk("R5 local read blocked by one write", rdy, 1'b0);
    pulse(5'b11000);
    chk("R5 local read after writes drain", rdy, 1'b1);
    chk("R10 no error yet", cnt_err, 1'b0);
    pulse(5'b01000);
    chk("R10 underflow flagged", cnt_err, 1'b1);
    chk("R10 counter held at zero", rdy, 1'b1);
    @(negedge clk); #1;
    chk("R10 error sticky", cnt_err, 1'b1);

    // R8 local atomic bumps both counters
    set_op(4'd9, 3'd2); issue_take = 1'b1; #1;
    chk("R8 local atomic issue", rdy, 1'b1);
    @(negedge clk); issue_take = 1'b0;
    repeat (8) @(negedge clk);
    set_op(4'd7, 3'd2);
    chk("R8 atomic blocks local read", rdy, 1'b0);
    set_op(4'd8, 3'd2);
    chk("R8 atomic blocks local write", rdy, 1'b0);
    pulse(5'b01000);
    set_op(4'd7, 3'd2);
    chk("R8 read free after atomic write part", rdy, 1'b1);
    set_op(4'd8, 3'd2);
    chk("R8 write still blocked by atomic read part", rdy, 1'b0);
    pulse(5'b10100);
    chk("R8 write free after atomic done", rdy, 1'b1);

    // R8 flat on local path counts globally, R6 flat needs local bus
    @(negedge clk); flat_to_local = 1'b1; set_op(4'd14, 3'd4); issue_take = 1'b1; #1;
    chk("R6 flat write issue", rdy, 1'b1);
    @(negedge clk); issue_take = 1'b0; flat_to_local = 1'b0;
    set_op(4'd4, 3'd1);
    chk("R8 flat write counted in global space", rdy, 1'b0);
    set_op(4'd13, 3'd4);
    chk("R6 flat blocked by busy local bus", rdy, 1'b0);
    set_op(4'd4, 3'd1);
    pulse(5'b10010);
    chk("R8 global read after flat completes", rdy, 1'b1);

    // R12 take while not ready, R9 SIMD slot period
    @(negedge clk); opnd_ready = 1'b0; set_op(4'd1, 3'd0); issue_take = 1'b1; #1;
    chk("R9 alu waits for operands", rdy, 1'b0);
    @(negedge clk); opnd_ready = 1'b1; issue_take = 1'b0; #1;
    chk("R12 refused take loaded no timer", rdy, 1'b1);
    issue_take = 1'b1;
    @(negedge clk); issue_take = 1'b0; #1;
    chk("R9 slot busy after alu issue", rdy, 1'b0);
    repeat (2) @(negedge clk); #1;
    chk("R9 slot busy last cycle", rdy, 1'b0);
    @(negedge clk); #1;
    chk("R9 slot free after period", rdy, 1'b1);

    // R2 barrier stall and release
    set_op(4'd3, 3'd0); issue_take = 1'b1; #1;
    chk("R2 barrier issue", rdy, 1'b1);
    @(negedge clk); issue_take = 1'b0; #1;
    chk("R2 stall flag set", bar_wait, 1'b1);
    set_op(4'd1, 3'd0);
    repeat (3) @(negedge clk); #1;
    chk("R2 held at barrier", rdy, 1'b0);
    all_at_bar = 1'b1; #1;
    chk("R2 ready on release", rdy, 1'b1);
    @(negedge clk); all_at_bar = 1'b0; #1;
    chk("R2 stall flag cleared", bar_wait, 1'b0);
    chk("R2 ready after release", rdy, 1'b1);

    finish_run();
  end
endmodule